// File: doc/BRIEF.md
# Quadrature Edge Direction Decoder

This block converts the two phase signals of an incremental encoder into single-cycle count pulses, one pulse per qualifying edge, each marked as an increment or a decrement. It sits in front of a position counter, which is not part of the block. Both phase inputs are treated as asynchronous. Each passes through a synchroniser, and edges are found by comparing the newest synchronised sample with the one before it.

Two decode modes can be selected. In the fourfold-resolution mode, every edge on either phase counts, and the level of the opposite phase decides the direction. In the clock-with-direction mode, only edges of phase B count. The level of phase A at that edge gives the direction, and a control input chooses which B edges are active. A direction output holds the direction of the most recent pulse.

Top module: `qdec_top`

## Requirements
- R1: In fourfold mode (`modeSel` = 01), a B rise counts up when A is high and down when A is low, and a B fall counts down when A is high and up when A is low.
- R2: In fourfold mode, an A rise counts up when B is low and down when B is high, and an A fall counts up when B is high and down when B is low.
- R3: In clock-with-direction mode (`modeSel` = 10), edges of A alone never produce a pulse. An active B edge counts up when A is high and down when A is low.
- R4: In clock-with-direction mode, `edgeSel` picks the active B edges: 01 rising only, 10 falling only, 11 both, 00 none.
- R5: When synchronised A and B change in the same cycle, no pulse is produced in either mode.
- R6: With `modeSel` at 00 or 11, no pulse is produced.
- R7: For each counted edge, exactly one pulse lasts one cycle. It is high in the cycle after the third rising clock edge that samples the changed input: two synchroniser stages plus one output register.
- R8: `countUp` and `countDown` are never high together.
- R9: `dirUp` is 1 after reset. It becomes 1 with every up pulse and 0 with every down pulse, and it holds its value while no pulse is issued.
- R10: While reset is asserted, `countUp` and `countDown` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| phaseA | input | 1 | Encoder phase A, asynchronous |
| phaseB | input | 1 | Encoder phase B, asynchronous |
| modeSel | input | 2 | 00 off, 01 fourfold, 10 clock-with-direction, 11 off |
| edgeSel | input | 2 | Active B edges in clock-with-direction mode |
| countUp | output | 1 | One-cycle increment pulse |
| countDown | output | 1 | One-cycle decrement pulse |
| dirUp | output | 1 | Direction of the most recent pulse (1 = up) |

## Verification
The bench walks both rotation directions in fourfold mode, so all eight table entries are exercised. A swapped row would show up as a wrong-sign pulse that reverses position. A diagonal jump, where both phases change at once, is applied in both modes. A decoder that resolved it would count a step that the encoder never made. In clock-with-direction mode, A is toggled on its own and every edge-select code is applied. A design that let A edges through, or that inverted the edge-select bits, would count on the wrong half of the B waveform. The pulse cycle is pinned exactly, which catches a missing or extra synchroniser stage.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

  typedef enum logic [1:0] {
    MODE_OFF     = 2'b00,
    MODE_QUAD    = 2'b01,
    MODE_STEPDIR = 2'b10,
    MODE_RSVD    = 2'b11
  } modeT;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edgeSelT;

  // Strobes from the datapath to the control
  typedef struct packed {
    logic riseA;
    logic fallA;
    logic riseB;
    logic fallB;
    logic levelA;
    logic levelB;
  } phaseEventsT;

endpackage

// File: rtl/qdec_datapath.sv
module qdec_datapath
  import qdec_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        phaseA,
  input  logic        phaseB,
  output phaseEventsT events
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncA;
  logic [LAST:0] syncB;
  logic          prevA;
  logic          prevB;

  // Synchroniser chains, length set by SYNC_STAGES
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA[0] <= 1'b0;
      syncB[0] <= 1'b0;
    end else begin
      syncA[0] <= phaseA;
      syncB[0] <= phaseB;
    end
  end

  for (genvar g = 1; g < SYNC_STAGES; g++) begin : gSyncStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncA[g] <= 1'b0;
        syncB[g] <= 1'b0;
      end else begin
        syncA[g] <= syncA[g-1];
        syncB[g] <= syncB[g-1];
      end
    end
  end

  // Previous synchronised sample for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevA <= 1'b0;
      prevB <= 1'b0;
    end else begin
      prevA <= syncA[LAST];
      prevB <= syncB[LAST];
    end
  end

  always_comb begin
    events.riseA  = syncA[LAST] & ~prevA;
    events.fallA  = ~syncA[LAST] & prevA;
    events.riseB  = syncB[LAST] & ~prevB;
    events.fallB  = ~syncB[LAST] & prevB;
    events.levelA = syncA[LAST];
    events.levelB = syncB[LAST];
  end

endmodule

// File: rtl/qdec_control.sv
module qdec_control
  import qdec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  phaseEventsT events,
  input  modeT        mode,
  input  edgeSelT     edgeMode,
  output logic        countUp,
  output logic        countDown,
  output logic        dirUp
);

  logic anyA;
  logic anyB;
  logic collide;
  logic bActive;
  logic upReq;
  logic downReq;

  always_comb begin
    anyA    = events.riseA | events.fallA;
    anyB    = events.riseB | events.fallB;
    collide = anyA & anyB;
    bActive = (events.riseB & edgeMode[0]) | (events.fallB & edgeMode[1]);
    upReq   = 1'b0;
    downReq = 1'b0;
    unique case (mode)
      MODE_QUAD: begin
        if (!collide) begin
          // Fourfold decode table
          case ({events.riseB, events.fallB, events.riseA, events.fallA})
            4'b1000: begin upReq =  events.levelA; downReq = ~events.levelA; end
            4'b0100: begin upReq = ~events.levelA; downReq =  events.levelA; end
            4'b0010: begin upReq = ~events.levelB; downReq =  events.levelB; end
            4'b0001: begin upReq =  events.levelB; downReq = ~events.levelB; end
            default: begin upReq = 1'b0; downReq = 1'b0; end
          endcase
        end
      end
      MODE_STEPDIR: begin
        if (bActive && !anyA) begin
          upReq   =  events.levelA;
          downReq = ~events.levelA;
        end
      end
      default: begin
        upReq   = 1'b0;
        downReq = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countUp   <= 1'b0;
      countDown <= 1'b0;
      dirUp     <= 1'b1;
    end else begin
      countUp   <= upReq;
      countDown <= downReq;
      if (upReq)
        dirUp <= 1'b1;
      else if (downReq)
        dirUp <= 1'b0;
    end
  end

endmodule

// File: rtl/qdec_top.sv
module qdec_top
  import qdec_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       phaseA,
  input  logic       phaseB,
  input  logic [1:0] modeSel,
  input  logic [1:0] edgeSel,
  output logic       countUp,
  output logic       countDown,
  output logic       dirUp
);

  phaseEventsT events;

  qdec_datapath #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_datapath (
    .clk   (clk),
    .rstN  (rstN),
    .phaseA(phaseA),
    .phaseB(phaseB),
    .events(events)
  );

  qdec_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .events   (events),
    .mode     (modeT'(modeSel)),
    .edgeMode (edgeSelT'(edgeSel)),
    .countUp  (countUp),
    .countDown(countDown),
    .dirUp    (dirUp)
  );

endmodule

// File: rtl/qdec_checker.sv
module qdec_checker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] modeSel,
  input logic [1:0] edgeSel,
  input logic       countUp,
  input logic       countDown,
  input logic       dirUp
);

  AST_UP_DOWN_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(countUp && countDown)); // R8

  AST_OFF_MODE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ($past(modeSel) == 2'b00 || $past(modeSel) == 2'b11) |-> (!countUp && !countDown)); // R6

  AST_NO_ACTIVE_EDGE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    ($past(modeSel) == 2'b10 && $past(edgeSel) == 2'b00) |-> (!countUp && !countDown)); // R4

  AST_DIR_ON_UP: assert property (@(posedge clk) disable iff (!rstN)
    countUp |-> dirUp); // R9

  AST_DIR_ON_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    countDown |-> !dirUp); // R9

  AST_DIR_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!countUp && !countDown) |-> $stable(dirUp)); // R9

  always @(posedge clk) begin
    if (!rstN) begin
      AST_RESET_QUIET: assert (!countUp && !countDown); // R10
    end
  end

endmodule

bind qdec_top qdec_checker u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .modeSel  (modeSel),
  .edgeSel  (edgeSel),
  .countUp  (countUp),
  .countDown(countDown),
  .dirUp    (dirUp)
);

// File: tb/qdec_top_tb.sv
module qdec_top_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       phaseA = 1'b0;
  logic       phaseB = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic [1:0] edgeSel = 2'b00;
  logic       countUp;
  logic       countDown;
  logic       dirUp;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qdec_top u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .phaseA   (phaseA),
    .phaseB   (phaseB),
    .modeSel  (modeSel),
    .edgeSel  (edgeSel),
    .countUp  (countUp),
    .countDown(countDown),
    .dirUp    (dirUp)
  );

  task automatic checkVal(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
    end
  endtask

  // Drive new phase levels, then count pulses over the following four cycles
  task automatic step(input logic a, input logic b, input int expUp,
                      input int expDown, input string tag);
    int ups = 0;
    int downs = 0;
    int both = 0;
    @(negedge clk);
    phaseA = a;
    phaseB = b;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (countUp) ups++;
      if (countDown) downs++;
      if (countUp && countDown) both++;
    end
    checkVal({tag, " up pulses"}, ups, expUp);
    checkVal({tag, " down pulses"}, downs, expDown);
    checkVal("R8 simultaneous up and down", both, 0);
  endtask

  // Move phases silently with decoding switched off
  task automatic setLevels(input logic a, input logic b);
    logic [1:0] saved = modeSel;
    @(negedge clk);
    modeSel = 2'b00;
    phaseA = a;
    phaseB = b;
    repeat (5) @(negedge clk);
    modeSel = saved;
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    checkVal("R10 countUp in reset", int'(countUp), 0);
    checkVal("R10 countDown in reset", int'(countDown), 0);
    checkVal("R9 dirUp after reset", int'(dirUp), 1);
    @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic testQuadForward();
    modeSel = 2'b01;
    setLevels(1'b0, 1'b0);
    step(1'b1, 1'b0, 1, 0, "R2 A rise B low");
    step(1'b1, 1'b1, 1, 0, "R1 B rise A high");
    step(1'b0, 1'b1, 1, 0, "R2 A fall B high");
    step(1'b0, 1'b0, 1, 0, "R1 B fall A low");
    checkVal("R9 dirUp after up run", int'(dirUp), 1);
  endtask

  task automatic testQuadReverse();
    modeSel = 2'b01;
    setLevels(1'b0, 1'b0);
    step(1'b0, 1'b1, 0, 1, "R1 B rise A low");
    step(1'b1, 1'b1, 0, 1, "R2 A rise B high");
    step(1'b1, 1'b0, 0, 1, "R1 B fall A high");
    step(1'b0, 1'b0, 0, 1, "R2 A fall B low");
    checkVal("R9 dirUp after down run", int'(dirUp), 0);
  endtask

  task automatic testLatency();
    int seen [4];
    modeSel = 2'b01;
    setLevels(1'b0, 1'b0);
    @(negedge clk);
    phaseA = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      seen[i] = int'(countUp);
    end
    checkVal("R7 no pulse after 1st edge", seen[0], 0);
    checkVal("R7 no pulse after 2nd edge", seen[1], 0);
    checkVal("R7 pulse after 3rd edge", seen[2], 1);
    checkVal("R7 pulse one cycle wide", seen[3], 0);
  endtask

  task automatic testCollision();
    modeSel = 2'b01;
    setLevels(1'b0, 1'b0);
    step(1'b1, 1'b1, 0, 0, "R5 fourfold diagonal rise");
    step(1'b0, 1'b0, 0, 0, "R5 fourfold diagonal fall");
    modeSel = 2'b10;
    edgeSel = 2'b11;
    setLevels(1'b1, 1'b1);
    step(1'b0, 1'b0, 0, 0, "R5 step-dir diagonal");
  endtask

  task automatic testStepDir();
    modeSel = 2'b10;
    edgeSel = 2'b01;
    setLevels(1'b0, 1'b0);
    step(1'b1, 1'b0, 0, 0, "R3 A rise ignored");
    step(1'b1, 1'b1, 1, 0, "R4 rising B, A high");
    step(1'b1, 1'b0, 0, 0, "R4 falling B inactive");
    step(1'b0, 1'b0, 0, 0, "R3 A fall ignored");
    step(1'b0, 1'b1, 0, 1, "R3 rising B, A low");
    edgeSel = 2'b10;
    step(1'b0, 1'b0, 0, 1, "R4 falling B, A low");
    step(1'b1, 1'b0, 0, 0, "R3 A rise ignored fall mode");
    step(1'b1, 1'b1, 0, 0, "R4 rising B inactive");
    step(1'b1, 1'b0, 1, 0, "R4 falling B, A high");
    edgeSel = 2'b11;
    step(1'b1, 1'b1, 1, 0, "R4 both, rising B");
    step(1'b1, 1'b0, 1, 0, "R4 both, falling B");
    edgeSel = 2'b00;
    step(1'b1, 1'b1, 0, 0, "R4 none, rising B");
    step(1'b1, 1'b0, 0, 0, "R4 none, falling B");
  endtask

  task automatic testOff();
    modeSel = 2'b01;
    setLevels(1'b0, 1'b0);
    step(1'b0, 1'b1, 0, 1, "R1 setup down pulse");
    modeSel = 2'b00;
    step(1'b1, 1'b1, 0, 0, "R6 mode 00 A edge");
    step(1'b1, 1'b0, 0, 0, "R6 mode 00 B edge");
    modeSel = 2'b11;
    edgeSel = 2'b11;
    step(1'b1, 1'b1, 0, 0, "R6 mode 11 B edge");
    step(1'b0, 1'b1, 0, 0, "R6 mode 11 A edge");
    checkVal("R9 dirUp held without pulses", int'(dirUp), 0);
  endtask

  initial begin
    testReset();
    testQuadForward();
    testQuadReverse();
    testLatency();
    testCollision();
    testStepDir();
    testOff();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule